// File: doc/BRIEF.md
# Serial programming target interface

This block is the device-side end of an in-system programming link. A host drives a serial clock, a data line into the device and an active-low programming select. The block returns data on a serial output. Each instruction is a fixed frame of four bytes. The block collects these frames and decodes them into requests to a memory subsystem. That subsystem holds the flash page buffer, the flash array and the EEPROM, and it answers on a simple request/response port.

The serial pins are sampled with the fast core clock through synchronizers, so the serial clock must be several core cycles per half period. Nothing is accepted until an enable frame, opcode 0xAC followed by 0x53, has been seen. A correct enable frame returns 0x53 while its third byte is clocked, which tells the host that the link is in step. If the first byte of a frame is not 0xAC before sync, the block refuses to synchronize until the programming select is released and asserted again.

Top module: `isp_target`

## Requirements
- R1: Serial input is taken on the rising serial-clock edge, most significant bit first. The request address is {byte 1, byte 2} of the frame and the write data is byte 3.
- R2: The serial output changes only after a falling serial-clock edge (or on leaving programming), most significant bit first. The first bit of each output byte appears after the falling edge that ends the previous byte.
- R3: Every frame is exactly four bytes. Byte counting wraps after byte 3 whatever the content or sync state.
- R4: A frame whose bytes 0 and 1 are 0xAC and 0x53 returns 0x53 on the output during byte 2, unless the block is locked out. An unsynchronized, non-locked block becomes synchronized at the end of such a frame. A frame of 0xAC with a different byte 1 gives no echo and no lockout.
- R5: While unsynchronized, no frame issues a memory request.
- R6: When synchronized, opcodes 0x20, 0x28 and 0xA0 (flash low, flash high, EEPROM read) issue a request with codes 4, 5 and 6 after byte 2. The response is returned as byte 3 on the output. Reads are accepted while a write is busy.
- R7: When synchronized, opcodes 0x40, 0x48, 0x4C and 0xC0 issue request codes 0, 1, 2 and 3 after byte 3. Codes 2 and 3 make the block busy until a completion pulse. Frames with codes 0 to 3 that arrive while busy issue no request.
- R8: Releasing the programming select resets the bit and byte counters, clears sync and lockout, and drives the output to 0. A frame that was aborted midway has no effect on the next frame.
- R9: An unsynchronized frame whose byte 0 is not 0xAC locks the block out. While locked out, no echo and no sync happen until the select is released.
- R10: Output bytes other than the echo and the read data are 0x00. Unknown opcodes issue no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isp_sck | input | 1 | Serial clock from host, idle low |
| isp_mosi | input | 1 | Serial data from host |
| isp_miso | output | 1 | Serial data to host |
| prog_n | input | 1 | Active-low programming select |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_op | output | 3 | Request code (0 to 6) |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe and held |
| mem_done | input | 1 | Completion pulse for busy writes |

## Verification
A wrong bit or byte count shows up within one frame. The echo lands in the wrong byte slot, or a request address comes out rotated. A wrong sync or lockout flag shows up at the next frame: an echo is present or missing, or an unexpected or missing request appears. The bench compares every request against its own queue in the cycle it appears. A stuck busy flag shows up as a missing write request in the first write frame after completion.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 4;
  localparam int BYTE_CW     = $clog2(FRAME_BYTES);
  localparam int BIT_CW      = $clog2(BYTE_W);

  localparam logic [7:0] OPC_ENABLE  = 8'hAC;
  localparam logic [7:0] SYNC_TOKEN  = 8'h53;
  localparam logic [7:0] OPC_LOAD_LO = 8'h40;
  localparam logic [7:0] OPC_LOAD_HI = 8'h48;
  localparam logic [7:0] OPC_PAGE_WR = 8'h4C;
  localparam logic [7:0] OPC_EE_WR   = 8'hC0;
  localparam logic [7:0] OPC_RD_LO   = 8'h20;
  localparam logic [7:0] OPC_RD_HI   = 8'h28;
  localparam logic [7:0] OPC_EE_RD   = 8'hA0;

  typedef enum logic [2:0] {
    MOP_LOAD_LO = 3'd0,
    MOP_LOAD_HI = 3'd1,
    MOP_PAGE_WR = 3'd2,
    MOP_EE_WR   = 3'd3,
    MOP_RD_LO   = 3'd4,
    MOP_RD_HI   = 3'd5,
    MOP_EE_RD   = 3'd6,
    MOP_NONE    = 3'd7
  } mem_op_e;

  function automatic mem_op_e decode_op(input logic [7:0] opc);
    case (opc)
      OPC_LOAD_LO: decode_op = MOP_LOAD_LO;
      OPC_LOAD_HI: decode_op = MOP_LOAD_HI;
      OPC_PAGE_WR: decode_op = MOP_PAGE_WR;
      OPC_EE_WR:   decode_op = MOP_EE_WR;
      OPC_RD_LO:   decode_op = MOP_RD_LO;
      OPC_RD_HI:   decode_op = MOP_RD_HI;
      OPC_EE_RD:   decode_op = MOP_EE_RD;
      default:     decode_op = MOP_NONE;
    endcase
  endfunction

  function automatic logic op_is_read(input mem_op_e op);
    op_is_read = (op == MOP_RD_LO) || (op == MOP_RD_HI) || (op == MOP_EE_RD);
  endfunction

  function automatic logic op_is_write(input mem_op_e op);
    op_is_write = (op == MOP_LOAD_LO) || (op == MOP_LOAD_HI) ||
                  (op == MOP_PAGE_WR) || (op == MOP_EE_WR);
  endfunction

  function automatic logic op_sets_busy(input mem_op_e op);
    op_sets_busy = (op == MOP_PAGE_WR) || (op == MOP_EE_WR);
  endfunction
endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prog_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_o,
  output logic active_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sck_q, mosi_q, prog_q;
  logic         sck_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= '0;
      mosi_q     <= '0;
      prog_q     <= '1;
      sck_last_q <= 1'b0;
    end else begin
      sck_q      <= {sck_q[TOP-1:0], sck_i};
      mosi_q     <= {mosi_q[TOP-1:0], mosi_i};
      prog_q     <= {prog_q[TOP-1:0], prog_n_i};
      sck_last_q <= sck_q[TOP];
    end
  end

  assign active_o = ~prog_q[TOP];
  assign mosi_o   = mosi_q[TOP];
  assign sck_rise = active_o &  sck_q[TOP] & ~sck_last_q;
  assign sck_fall = active_o & ~sck_q[TOP] &  sck_last_q;
endmodule

// File: rtl/isp_frame_shift.sv
module isp_frame_shift
  import isp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               mosi,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic               byte_done,
  output logic [BYTE_CW-1:0] done_idx,
  output logic [BYTE_W-1:0]  done_byte,
  output logic [BYTE_CW-1:0] byte_cnt,
  output logic [BIT_CW-1:0]  bit_idx,
  output logic               miso
);
  localparam logic [BIT_CW-1:0]  BIT_TOP   = BIT_CW'(BYTE_W - 1);
  localparam logic [BYTE_CW-1:0] BYTE_LAST = BYTE_CW'(FRAME_BYTES - 1);

  logic [BIT_CW-1:0]  bit_q, bit_d;
  logic [BYTE_CW-1:0] cnt_q, cnt_d, didx_q, didx_d;
  logic [BYTE_W-1:0]  rx_q, rx_d, tx_q, tx_d, dbyte_q, dbyte_d;
  logic               done_q, done_d;

  always_comb begin
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    didx_d  = didx_q;
    dbyte_d = dbyte_q;
    done_d  = 1'b0;
    if (!active) begin
      bit_d = BIT_TOP;
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = '0;
    end else if (sck_rise) begin
      rx_d = {rx_q[BYTE_W-2:0], mosi};
      if (bit_q == '0) begin
        done_d  = 1'b1;
        didx_d  = cnt_q;
        dbyte_d = rx_d;
        bit_d   = BIT_TOP;
        cnt_d   = (cnt_q == BYTE_LAST) ? '0 : cnt_q + 1'b1;
      end else begin
        bit_d = bit_q - 1'b1;
      end
    end else if (sck_fall) begin
      if (bit_q == BIT_TOP) tx_d = tx_byte;
      else                  tx_d = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= BIT_TOP;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      didx_q  <= '0;
      dbyte_q <= '0;
      done_q  <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      didx_q  <= didx_d;
      dbyte_q <= dbyte_d;
      done_q  <= done_d;
    end
  end

  assign byte_done = done_q;
  assign done_idx  = didx_q;
  assign done_byte = dbyte_q;
  assign byte_cnt  = cnt_q;
  assign bit_idx   = bit_q;
  assign miso      = tx_q[BYTE_W-1];
endmodule

// File: rtl/isp_cmd_ctrl.sv
module isp_cmd_ctrl
  import isp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                byte_done,
  input  logic [BYTE_CW-1:0]  done_idx,
  input  logic [BYTE_W-1:0]   done_byte,
  input  logic [BYTE_CW-1:0]  byte_cnt,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic                mem_done,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                mem_req,
  output logic [2:0]          mem_op,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                synced,
  output logic                locked,
  output logic                busy
);
  localparam logic [BYTE_CW-1:0] IDX_ADDR_HI = BYTE_CW'(1);
  localparam logic [BYTE_CW-1:0] IDX_ADDR_LO = BYTE_CW'(2);
  localparam logic [BYTE_CW-1:0] IDX_DATA    = BYTE_CW'(3);

  logic [BYTE_W-1:0]   opc_q, opc_d, ahi_q, ahi_d, alo_q, alo_d;
  logic [BYTE_W-1:0]   rdata_q, rdata_d, wdata_q, wdata_d;
  logic [2*BYTE_W-1:0] addr_q, addr_d;
  mem_op_e             op_q, op_d, cur_op;
  logic synced_q, synced_d, locked_q, locked_d, busy_q, busy_d;
  logic echo_q, echo_d, rd_q, rd_d, rdw_q, rdw_d, req_q, req_d;

  assign cur_op = decode_op(opc_q);

  always_comb begin
    opc_d = opc_q;   ahi_d = ahi_q;   alo_d = alo_q;
    rdata_d = rdata_q; wdata_d = wdata_q; addr_d = addr_q; op_d = op_q;
    synced_d = synced_q; locked_d = locked_q; busy_d = busy_q;
    echo_d = echo_q; rd_d = rd_q;
    rdw_d = 1'b0;
    req_d = 1'b0;
    if (rdw_q)    rdata_d = mem_rdata;
    if (mem_done) busy_d  = 1'b0;
    if (!active) begin
      synced_d = 1'b0;
      locked_d = 1'b0;
      echo_d   = 1'b0;
      rd_d     = 1'b0;
    end else if (byte_done) begin
      if (done_idx == IDX_ADDR_HI) begin
        ahi_d  = done_byte;
        echo_d = (opc_q == OPC_ENABLE) && (done_byte == SYNC_TOKEN) && !locked_q;
      end else if (done_idx == IDX_ADDR_LO) begin
        alo_d = done_byte;
        rd_d  = synced_q && op_is_read(cur_op);
        if (rd_d) begin
          req_d   = 1'b1;
          rdw_d   = 1'b1;
          op_d    = cur_op;
          addr_d  = {ahi_q, done_byte};
          wdata_d = '0;
        end
      end else if (done_idx == IDX_DATA) begin
        if (!synced_q) begin
          if (opc_q != OPC_ENABLE)                       locked_d = 1'b1;
          else if (ahi_q == SYNC_TOKEN && !locked_q)     synced_d = 1'b1;
        end else if (op_is_write(cur_op) && !busy_q) begin
          req_d   = 1'b1;
          op_d    = cur_op;
          addr_d  = {ahi_q, alo_q};
          wdata_d = done_byte;
          if (op_sets_busy(cur_op)) busy_d = 1'b1;
        end
      end else begin
        opc_d = done_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_d_reg_reset();
    end else begin
      opc_q <= opc_d;   ahi_q <= ahi_d;   alo_q <= alo_d;
      rdata_q <= rdata_d; wdata_q <= wdata_d; addr_q <= addr_d; op_q <= op_d;
      synced_q <= synced_d; locked_q <= locked_d; busy_q <= busy_d;
      echo_q <= echo_d; rd_q <= rd_d; rdw_q <= rdw_d; req_q <= req_d;
    end
  end

  task automatic opc_d_reg_reset();
    opc_q <= '0;   ahi_q <= '0;   alo_q <= '0;
    rdata_q <= '0; wdata_q <= '0; addr_q <= '0; op_q <= MOP_NONE;
    synced_q <= 1'b0; locked_q <= 1'b0; busy_q <= 1'b0;
    echo_q <= 1'b0; rd_q <= 1'b0; rdw_q <= 1'b0; req_q <= 1'b0;
  endtask

  always_comb begin
    if (byte_cnt == IDX_ADDR_LO)   tx_byte = echo_q ? ahi_q : '0;
    else if (byte_cnt == IDX_DATA) tx_byte = rd_q ? rdata_q : '0;
    else                           tx_byte = '0;
  end

  assign mem_req   = req_q;
  assign mem_op    = op_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign synced    = synced_q;
  assign locked    = locked_q;
  assign busy      = busy_q;
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        isp_sck,
  input  logic        isp_mosi,
  output logic        isp_miso,
  input  logic        prog_n,
  output logic        mem_req,
  output logic [2:0]  mem_op,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_done
);
  logic               sck_rise, sck_fall, mosi_s, active;
  logic               byte_done;
  logic [BYTE_CW-1:0] done_idx, byte_cnt;
  logic [BYTE_W-1:0]  done_byte, tx_byte;
  logic [BIT_CW-1:0]  bit_idx;
  logic               synced, locked, busy;

  isp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(isp_sck), .mosi_i(isp_mosi),
    .prog_n_i(prog_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_o(mosi_s), .active_o(active)
  );

  isp_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi(mosi_s), .tx_byte(tx_byte),
    .byte_done(byte_done), .done_idx(done_idx), .done_byte(done_byte),
    .byte_cnt(byte_cnt), .bit_idx(bit_idx), .miso(isp_miso)
  );

  isp_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .active(active), .byte_done(byte_done),
    .done_idx(done_idx), .done_byte(done_byte), .byte_cnt(byte_cnt),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .tx_byte(tx_byte),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .synced(synced), .locked(locked), .busy(busy)
  );
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk
  import isp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               isp_miso,
  input logic               sck_fall,
  input logic               active,
  input logic [BIT_CW-1:0]  bit_idx,
  input logic [BYTE_CW-1:0] byte_cnt,
  input logic               mem_req,
  input logic [2:0]         mem_op,
  input logic               synced,
  input logic               locked,
  input logic               busy
);
  assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(isp_miso) |-> ($past(sck_fall) || !$past(active)));

  assert_counters_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_idx == BIT_CW'(BYTE_W - 1) && byte_cnt == '0));

  assert_req_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(synced));

  assert_no_write_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_op <= 3'd3) |-> !$past(busy));

  assert_lock_excludes_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !synced);
endmodule

bind isp_target isp_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .isp_miso(isp_miso), .sck_fall(sck_fall),
  .active(active), .bit_idx(bit_idx), .byte_cnt(byte_cnt),
  .mem_req(mem_req), .mem_op(mem_op), .synced(synced), .locked(locked),
  .busy(busy)
);

// File: tb/isp_target_tb_top.sv
`timescale 1ns/1ps
module isp_target_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sck, mosi, prog_n, mem_done;
  logic [7:0]  mem_rdata;
  logic        miso, mem_req;
  logic [2:0]  mem_op;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  isp_target dut_i (
    .clk(clk), .rst_n(rst_n), .isp_sck(sck), .isp_mosi(mosi), .isp_miso(miso),
    .prog_n(prog_n), .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [2:0] op; logic [15:0] addr; logic [7:0] wd; } req_t;
  req_t exp_q[$];
  string cur_tag = "R5";

  int done_delay = 20;
  int busy_cnt   = 0;
  bit mem_busy   = 0;
  bit m_synced   = 0;
  bit m_locked   = 0;

  function automatic logic [7:0] rd_val(input logic [2:0] op, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, op} ^ 8'h3C;
  endfunction

  // bench memory and per-clock request comparison
  always @(negedge clk) begin
    mem_done = 1'b0;
    if (mem_busy) begin
      if (busy_cnt == 0) begin mem_done = 1'b1; mem_busy = 0; end
      else busy_cnt--;
    end
    if (rst_n && mem_req === 1'b1) begin
      if (mem_op >= 3'd4) mem_rdata = rd_val(mem_op, mem_addr);
      if (mem_op == 3'd2 || mem_op == 3'd3) begin mem_busy = 1; busy_cnt = done_delay; end
      if (exp_q.size() == 0) begin
        check(0, cur_tag, "unexpected request op", int'(mem_op), 7);
      end else begin
        req_t e;
        e = exp_q.pop_front();
        check(mem_op == e.op, cur_tag, "request op", int'(mem_op), int'(e.op));
        check(mem_addr == e.addr, cur_tag, "request addr (R1)", int'(mem_addr), int'(e.addr));
        check(mem_wdata == e.wd, cur_tag, "request wdata (R1)", int'(mem_wdata), int'(e.wd));
      end
    end
  end

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic pulse_prog();
    prog_n = 1'b1;
    repeat (10) @(negedge clk);
    prog_n = 1'b0;
    repeat (10) @(negedge clk);
    m_synced = 0;
    m_locked = 0;
  endtask

  task automatic run_frame(input logic [7:0] b0, b1, b2, b3, input string tag);
    logic [7:0] tx [4];
    logic [7:0] ex [4];
    logic [7:0] rx;
    logic [2:0] op;
    bit is_rd, is_wr;
    req_t r;
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3;
    ex[0] = 8'h00; ex[1] = 8'h00; ex[2] = 8'h00; ex[3] = 8'h00;
    cur_tag = tag;
    case (b0)
      8'h40: op = 3'd0;  8'h48: op = 3'd1;  8'h4C: op = 3'd2;  8'hC0: op = 3'd3;
      8'h20: op = 3'd4;  8'h28: op = 3'd5;  8'hA0: op = 3'd6;  default: op = 3'd7;
    endcase
    is_rd = (op >= 3'd4 && op <= 3'd6);
    is_wr = (op <= 3'd3);
    if (b0 == 8'hAC && b1 == 8'h53 && !m_locked) ex[2] = 8'h53;
    if (m_synced && is_rd) begin
      ex[3] = rd_val(op, {b1, b2});
      r.op = op; r.addr = {b1, b2}; r.wd = 8'h00;
      exp_q.push_back(r);
    end
    if (m_synced && is_wr && !mem_busy) begin
      r.op = op; r.addr = {b1, b2}; r.wd = b3;
      exp_q.push_back(r);
    end
    if (!m_synced) begin
      if (b0 != 8'hAC) m_locked = 1;
      else if (b1 == 8'h53 && !m_locked) m_synced = 1;
    end
    for (int k = 0; k < 4; k++) begin
      xfer_bits(tx[k], 8, rx);
      check(rx == ex[k], tag, $sformatf("miso byte %0d (R2 R10)", k), int'(rx), int'(ex[k]));
    end
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, "missing requests", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] dummy;
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; prog_n = 1'b1;
    mem_done = 1'b0; mem_rdata = 8'h00;
    repeat (5) @(negedge clk);
    check(miso == 1'b0, "R10", "miso in reset", int'(miso), 0);
    check(mem_req == 1'b0, "R5", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    prog_n = 1'b0;
    repeat (10) @(negedge clk);

    run_frame(8'hAC, 8'h11, 8'h00, 8'h00, "R4");      // wrong token, no lockout
    run_frame(8'h40, 8'h00, 8'h05, 8'h33, "R9");      // bad first byte locks
    run_frame(8'hAC, 8'h53, 8'h00, 8'h00, "R9");      // locked: no echo
    run_frame(8'h20, 8'h00, 8'h10, 8'h00, "R5");
    pulse_prog();
    run_frame(8'hAC, 8'h53, 8'h00, 8'h00, "R4");      // echo and sync
    run_frame(8'h20, 8'h01, 8'h23, 8'h00, "R6");
    run_frame(8'h28, 8'h83, 8'h45, 8'h00, "R6");
    run_frame(8'h40, 8'h00, 8'h07, 8'hA5, "R7");
    run_frame(8'h48, 8'h00, 8'h07, 8'h5B, "R7");
    done_delay = 3000;
    run_frame(8'hC0, 8'h01, 8'h02, 8'h77, "R7");
    run_frame(8'h40, 8'h00, 8'h08, 8'h11, "R7");      // ignored while busy
    run_frame(8'hA0, 8'h01, 8'h02, 8'h00, "R6");      // read while busy
    while (mem_busy) @(negedge clk);
    done_delay = 20;
    run_frame(8'h4C, 8'h00, 8'h20, 8'h00, "R7");
    while (mem_busy) @(negedge clk);
    run_frame(8'h40, 8'h00, 8'h09, 8'hC3, "R7");      // accepted again after done
    run_frame(8'h99, 8'h12, 8'h34, 8'h56, "R10");
    run_frame(8'hAC, 8'h53, 8'h00, 8'h00, "R4");

    // abort midway through a frame (R3 R8)
    cur_tag = "R8";
    xfer_bits(8'hAC, 8, dummy);
    xfer_bits(8'h53, 4, dummy);
    pulse_prog();
    check(miso == 1'b0, "R8", "miso after select release", int'(miso), 0);
    run_frame(8'h20, 8'h00, 8'h01, 8'h00, "R8");      // sync cleared: no request
    pulse_prog();
    run_frame(8'hAC, 8'h53, 8'h00, 8'h00, "R3");      // counters restart at byte 0
    run_frame(8'h28, 8'h00, 8'h44, 8'h00, "R1");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule